// File: doc/BRIEF.md
# Static Memory Bank Read Sequencer

This block drives the read cycle of one external ROM or SRAM bank. An internal requester presents a word address with a single-cycle valid strobe while the sequencer is ready. The sequencer then walks the external bus through a fixed series of phases: address setup, chip-select setup, the access period, output-enable hold and address hold. For each datum it captures the external data and returns it with a one-clock acknowledge. Each phase length comes from a 15-bit bank-control register. The 2-bit phase fields and the 3-bit access field use non-linear encodings.

An optional page mode keeps chip select and output enable asserted across 4, 8 or 16 consecutive beats. It advances the address by one for each beat, and every beat after the first uses its own page access time. Setup phases come only before the first beat and hold phases only after the last. The sequencer takes a copy of the register when it accepts a request, so a register write made during a cycle only changes later cycles. Two strap pins give the bank width and one gives the byte order. Both appear unchanged on read-only status outputs. Every count is in bus clocks, and the block runs on the bus clock.

Top module: `srom_read_seq`

## Requirements
- R1: After reset the control register reads 0x0700, chip select and output enable are high (inactive), ready is high and acknowledge is low.
- R2: `bus_width_o` equals the 2-bit width strap (00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = test mode) and `big_endian_o` equals the byte-order strap (0 = little, 1 = big).
- R3: The four 2-bit phase fields use codes 00/01/10/11 = 0/1/2/4 clocks: address setup at bits [14:13], chip-select-to-output-enable setup at [12:11], chip-select hold after output enable at [7:6], and address hold after chip select at [5:4]. A zero-length phase is skipped.
- R4: The access field at bits [10:8] maps codes 0..7 to 1, 2, 3, 4, 6, 8, 10 and 14 clocks.
- R5: After the accept edge the bus passes through these phases in order: setup (both strobes high, address valid), chip-select setup (chip select low), access (both low), output-enable hold (chip select low only), and address hold (both high, address unchanged).
- R6: Read data is captured on the last clock of each access or page beat. `req_ack_o` is high for exactly the following clock, and `rd_data_o` holds that datum.
- R7: The page field at bits [1:0] selects 1/4/8/16 beats (00/01/10/11). Beats after the first last the page time at bits [3:2] (00/01/10/11 = 2/3/4/6 clocks), and beat k drives address base+k (modulo 2^AW).
- R8: A register write takes effect on `cfg_rdata_o` on the next clock. A cycle already in progress continues with the settings latched when its request was accepted.
- R9: A request is accepted only on a clock where `req_ready_o` is high. While a cycle is running, `req_valid_i` and `req_addr_i` have no effect on the bus.
- R10: With the register at 0x1A00 a cycle has no address setup, 4 clocks of chip-select setup, a 3-clock access and no hold phases, so it takes 7 clocks in total.
- R11: Output enable is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the bank-control register |
| cfg_wdata_i | input | 15 | New bank-control register value |
| cfg_rdata_o | output | 15 | Current bank-control register value |
| strap_width_i | input | 2 | Bus-width strap pins |
| strap_endian_i | input | 1 | Byte-order strap pin |
| bus_width_o | output | 2 | Read-only bus-width status |
| big_endian_o | output | 1 | Read-only byte-order status |
| req_valid_i | input | 1 | Read request strobe |
| req_addr_i | input | AW | Word address of the request |
| req_ready_o | output | 1 | Sequencer idle and able to accept a request |
| req_ack_o | output | 1 | One-clock pulse for each captured datum |
| rd_data_o | output | DW | Captured read data |
| mem_addr_o | output | AW | External address bus |
| mem_cs_n_o | output | 1 | External chip select, active low |
| mem_oe_n_o | output | 1 | External output enable, active low |
| mem_data_i | input | DW | External read data |

## Verification
The assertions watch every clock for strobe nesting (R11), an idle bus whenever the sequencer is ready, acknowledges that only follow a clock with output enable asserted, an address that stays fixed while chip select is held without output enable, and the drop of ready after an accepted request (R9). The exact length of each phase, the non-linear decodes, page address stepping, data capture and deferred register updates can only be shown by the bench. It sweeps every non-page combination of the phase fields and a page-mode grid, and compares every bus clock against a waveform it computes from the field values.

// File: rtl/srom_seq_pkg.sv
package srom_seq_pkg;

    localparam int CFG_W = 15;
    localparam int CNT_W = 5;
    localparam logic [CFG_W-1:0] CFG_RESET = 15'h0700;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ASET,
        PH_CSET,
        PH_ACC,
        PH_PAGE,
        PH_OHLD,
        PH_AHLD
    } phase_e;

    // packed so that bit positions follow the register layout
    typedef struct packed {
        logic [1:0] aset;
        logic [1:0] cset;
        logic [2:0] acc;
        logic [1:0] ohld;
        logic [1:0] ahld;
        logic [1:0] page_t;
        logic [1:0] page_n;
    } bank_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] aset;
        logic [CNT_W-1:0] cset;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] ohld;
        logic [CNT_W-1:0] ahld;
        logic [CNT_W-1:0] page_t;
        logic [CNT_W-1:0] beats;
    } timing_t;

    function automatic logic [CNT_W-1:0] dec_edge(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd0;
            2'd1:    return 5'd1;
            2'd2:    return 5'd2;
            default: return 5'd4;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] dec_acc(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd3;
            3'd3:    return 5'd4;
            3'd4:    return 5'd6;
            3'd5:    return 5'd8;
            3'd6:    return 5'd10;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] dec_page_t(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd2;
            2'd1:    return 5'd3;
            2'd2:    return 5'd4;
            default: return 5'd6;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] dec_beats(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/srom_cfg_reg.sv
module srom_cfg_reg
    import srom_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o
);

    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/srom_timing_dec.sv
module srom_timing_dec
    import srom_seq_pkg::*;
(
    input  bank_cfg_t cfg_i,
    output timing_t   tim_o
);

    always_comb begin
        tim_o.aset   = dec_edge(cfg_i.aset);
        tim_o.cset   = dec_edge(cfg_i.cset);
        tim_o.acc    = dec_acc(cfg_i.acc);
        tim_o.ohld   = dec_edge(cfg_i.ohld);
        tim_o.ahld   = dec_edge(cfg_i.ahld);
        tim_o.page_t = dec_page_t(cfg_i.page_t);
        tim_o.beats  = dec_beats(cfg_i.page_n);
    end

endmodule

// File: rtl/srom_phase_fsm.sv
module srom_phase_fsm
    import srom_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  timing_t       tim_i,
    input  logic [DW-1:0] din_i,
    output phase_e        phase_o,
    output logic [AW-1:0] addr_o,
    output logic          ack_o,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] beat;
        logic [AW-1:0]    base;
        logic [AW-1:0]    addr;
        logic             ack;
        logic [DW-1:0]    rdata;
        timing_t          tim;
    } state_t;

    state_t s_d, s_q;
    logic [CNT_W-1:0] nxt_beat;

    assign nxt_beat = s_q.beat + 5'd1;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start_i) begin
                s_d.tim  = tim_i;
                s_d.base = base_i;
                s_d.addr = base_i;
                s_d.beat = '0;
                if (tim_i.aset != '0) begin
                    s_d.phase = PH_ASET;
                    s_d.cnt   = tim_i.aset;
                end else if (tim_i.cset != '0) begin
                    s_d.phase = PH_CSET;
                    s_d.cnt   = tim_i.cset;
                end else begin
                    s_d.phase = PH_ACC;
                    s_d.cnt   = tim_i.acc;
                end
            end
        end else if (s_q.cnt > 5'd1) begin
            s_d.cnt = s_q.cnt - 5'd1;
        end else begin
            case (s_q.phase)
                PH_ASET: begin
                    if (s_q.tim.cset != '0) begin
                        s_d.phase = PH_CSET;
                        s_d.cnt   = s_q.tim.cset;
                    end else begin
                        s_d.phase = PH_ACC;
                        s_d.cnt   = s_q.tim.acc;
                    end
                end
                PH_CSET: begin
                    s_d.phase = PH_ACC;
                    s_d.cnt   = s_q.tim.acc;
                end
                PH_ACC, PH_PAGE: begin
                    s_d.ack   = 1'b1;
                    s_d.rdata = din_i;
                    if (nxt_beat < s_q.tim.beats) begin
                        s_d.beat  = nxt_beat;
                        s_d.addr  = s_q.base + AW'(nxt_beat);
                        s_d.phase = PH_PAGE;
                        s_d.cnt   = s_q.tim.page_t;
                    end else if (s_q.tim.ohld != '0) begin
                        s_d.phase = PH_OHLD;
                        s_d.cnt   = s_q.tim.ohld;
                    end else if (s_q.tim.ahld != '0) begin
                        s_d.phase = PH_AHLD;
                        s_d.cnt   = s_q.tim.ahld;
                    end else begin
                        s_d.phase = PH_IDLE;
                        s_d.cnt   = '0;
                    end
                end
                PH_OHLD: begin
                    if (s_q.tim.ahld != '0) begin
                        s_d.phase = PH_AHLD;
                        s_d.cnt   = s_q.tim.ahld;
                    end else begin
                        s_d.phase = PH_IDLE;
                        s_d.cnt   = '0;
                    end
                end
                default: begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign addr_o  = s_q.addr;
    assign ack_o   = s_q.ack;
    assign rdata_o = s_q.rdata;

endmodule

// File: rtl/srom_read_seq.sv
module srom_read_seq
    import srom_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic [1:0]       strap_width_i,
    input  logic             strap_endian_i,
    output logic [1:0]       bus_width_o,
    output logic             big_endian_o,
    input  logic             req_valid_i,
    input  logic [AW-1:0]    req_addr_i,
    output logic             req_ready_o,
    output logic             req_ack_o,
    output logic [DW-1:0]    rd_data_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic             mem_cs_n_o,
    output logic             mem_oe_n_o,
    input  logic [DW-1:0]    mem_data_i
);

    logic [CFG_W-1:0] cfg_word;
    bank_cfg_t        cfg_s;
    timing_t          tim_s;
    phase_e           phase_s;
    logic             start_s;

    srom_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg_word)
    );

    assign cfg_s = bank_cfg_t'(cfg_word);

    srom_timing_dec u_dec (
        .cfg_i (cfg_s),
        .tim_o (tim_s)
    );

    assign req_ready_o = (phase_s == PH_IDLE);
    assign start_s     = req_valid_i && req_ready_o;

    srom_phase_fsm #(
        .AW (AW),
        .DW (DW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_s),
        .base_i  (req_addr_i),
        .tim_i   (tim_s),
        .din_i   (mem_data_i),
        .phase_o (phase_s),
        .addr_o  (mem_addr_o),
        .ack_o   (req_ack_o),
        .rdata_o (rd_data_o)
    );

    always_comb begin
        mem_cs_n_o = 1'b1;
        mem_oe_n_o = 1'b1;
        case (phase_s)
            PH_CSET, PH_OHLD: mem_cs_n_o = 1'b0;
            PH_ACC, PH_PAGE: begin
                mem_cs_n_o = 1'b0;
                mem_oe_n_o = 1'b0;
            end
            default: ;
        endcase
    end

    assign cfg_rdata_o  = cfg_word;
    assign bus_width_o  = strap_width_i;
    assign big_endian_o = strap_endian_i;

endmodule

// File: rtl/srom_read_seq_chk.sv
module srom_read_seq_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid_i,
    input logic          req_ready_o,
    input logic          req_ack_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_cs_n_o,
    input logic          mem_oe_n_o
);

    // R11
    cs_oe_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_cs_n_o);

    // R5
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (mem_cs_n_o && mem_oe_n_o));

    // R6
    ack_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack_o |-> $past(!mem_oe_n_o));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R5
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && mem_oe_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));

endmodule

bind srom_read_seq srom_read_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_ack_o   (req_ack_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_oe_n_o  (mem_oe_n_o)
);

// File: tb/srom_read_seq_tb.sv
`timescale 1ns/1ps
module srom_read_seq_tb;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [14:0]   cfg_wdata = '0;
    logic [14:0]   cfg_rdata;
    logic [1:0]    strap_w = 2'd1;
    logic          strap_e = 1'b0;
    logic [1:0]    bw;
    logic          be;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, req_ack;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          cs_n, oe_n;
    logic [DW-1:0] mem_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
        return a[15:0] * 16'd7 ^ 16'h5A3C ^ {12'h0, a[19:16]};
    endfunction

    assign mem_data = rom_word(mem_addr);

    srom_read_seq #(.AW(AW), .DW(DW)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we_i       (cfg_we),
        .cfg_wdata_i    (cfg_wdata),
        .cfg_rdata_o    (cfg_rdata),
        .strap_width_i  (strap_w),
        .strap_endian_i (strap_e),
        .bus_width_o    (bw),
        .big_endian_o   (be),
        .req_valid_i    (req_valid),
        .req_addr_i     (req_addr),
        .req_ready_o    (req_ready),
        .req_ack_o      (req_ack),
        .rd_data_o      (rd_data),
        .mem_addr_o     (mem_addr),
        .mem_cs_n_o     (cs_n),
        .mem_oe_n_o     (oe_n),
        .mem_data_i     (mem_data)
    );

    function automatic int d_edge(input logic [1:0] c);
        return (c == 2'd3) ? 4 : int'(c);
    endfunction
    function automatic int d_acc(input logic [2:0] c);
        if (c < 3'd4) return int'(c) + 1;
        if (c == 3'd7) return 14;
        return 2 * int'(c) - 2;
    endfunction
    function automatic int d_pt(input logic [1:0] c);
        return (c == 2'd3) ? 6 : int'(c) + 2;
    endfunction
    function automatic int d_bt(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (2 << c);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [14:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // starts at a negedge with the sequencer idle; ends at a negedge, idle again
    task automatic run_req(input logic [14:0] cfg, input logic [AW-1:0] base,
                           input bit junk, input bit mid, input logic [14:0] mid_val,
                           input string req);
        int a, c, x, p, n, o, h, acc_end, total;
        a = d_edge(cfg[14:13]);
        c = d_edge(cfg[12:11]);
        x = d_acc(cfg[10:8]);
        o = d_edge(cfg[7:6]);
        h = d_edge(cfg[5:4]);
        p = d_pt(cfg[3:2]);
        n = d_bt(cfg[1:0]);
        acc_end = a + c + x + (n - 1) * p;
        total = acc_end + o + h;
        req_valid = 1'b1;
        req_addr = base;
        @(negedge clk);
        for (int k = 0; k <= total; k++) begin
            logic e_cs, e_oe, e_ack, e_rdy;
            logic [AW-1:0] e_addr;
            int bt;
            bt = 0;
            e_cs = 1'b1; e_oe = 1'b1;
            e_addr = base + AW'(n - 1);
            if (k < a) begin
                e_addr = base;
            end else if (k < a + c) begin
                e_cs = 1'b0; e_addr = base;
            end else if (k < acc_end) begin
                e_cs = 1'b0; e_oe = 1'b0;
                bt = (k < a + c + x) ? 0 : 1 + (k - a - c - x) / p;
                e_addr = base + AW'(bt);
            end else if (k < acc_end + o) begin
                e_cs = 1'b0;
            end
            e_ack = (k == a + c + x) || (k > a + c + x && k <= acc_end && ((k - a - c - x) % p) == 0);
            e_rdy = (k >= total);
            check(cs_n == e_cs && oe_n == e_oe && mem_addr == e_addr && req_ack == e_ack
                  && req_ready == e_rdy, req, $sformatf("bus k=%0d cfg=%h {cs,oe,ack,rdy,addr}", k, cfg),
                  {cs_n, oe_n, req_ack, req_ready, 40'(mem_addr)},
                  {e_cs, e_oe, e_ack, e_rdy, 40'(e_addr)});
            if (e_ack) begin
                int j;
                j = (k == a + c + x) ? 0 : (k - a - c - x) / p;
                check(rd_data == rom_word(base + AW'(j)), "R6", $sformatf("data beat %0d", j),
                      64'(rd_data), 64'(rom_word(base + AW'(j))));
            end
            req_valid = junk && (k < total);
            req_addr = ~base;
            cfg_we = mid && (k == 0);
            cfg_wdata = mid_val;
            @(negedge clk);
        end
        req_valid = 1'b0;
        cfg_we = 1'b0;
        check(req_ready && !req_ack && cs_n && oe_n, req, "idle after cycle",
              {req_ready, req_ack, cs_n, oe_n}, 4'b1011);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cfg_rdata == 15'h0700, "R1", "reset cfg", 64'(cfg_rdata), 64'h0700);
        check(cs_n && oe_n && !req_ack && req_ready, "R1", "reset pins",
              {cs_n, oe_n, req_ack, req_ready}, 4'b1101);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: straps
        for (int s = 0; s < 8; s++) begin
            strap_w = s[1:0];
            strap_e = s[2];
            #1;
            check(bw == s[1:0] && be == s[2], "R2", "strap status", {bw, be}, s[2:0]);
        end
        @(negedge clk);

        // R4: reset value gives a 14-clock access
        run_req(15'h0700, 20'h12345, 1'b0, 1'b0, '0, "R4");

        // R10: 0x1A00 -> 0+4+3+0+0 = 7 clocks
        check(d_edge(2'd3) + d_acc(3'd2) == 7, "R10", "cycle length", 7, 7);
        write_cfg(15'h1A00);
        run_req(15'h1A00, 20'h00ABC, 1'b0, 1'b0, '0, "R10");

        // R3 R4 R5 R9: every non-page setting, junk requests on odd ones
        for (int v = 0; v < 2048; v++) begin
            logic [14:0] cf;
            cf = {v[10:0], 4'b0000};
            write_cfg(cf);
            run_req(cf, AW'(v * 37), v[0], 1'b0, '0, "R5");
        end

        // R7: page mode grid, including address wrap
        for (int pn = 1; pn < 4; pn++) begin
            for (int pt = 0; pt < 4; pt++) begin
                for (int ac = 0; ac < 8; ac += 3) begin
                    logic [14:0] cf;
                    cf = {2'(ac % 3), 2'(pt), 3'(ac), 2'(pn), 2'(pt % 3), 2'(pt), 2'(pn)};
                    write_cfg(cf);
                    run_req(cf, 20'hFFFF8 + AW'(pt), pt[0], 1'b0, '0, "R7");
                end
            end
        end

        // R8: write during a cycle only applies to the next request
        write_cfg(15'h4A51);
        run_req(15'h4A51, 20'h0F00F, 1'b0, 1'b1, 15'h0B26, "R8");
        check(cfg_rdata == 15'h0B26, "R8", "readback after mid write", 64'(cfg_rdata), 64'h0B26);
        run_req(15'h0B26, 20'h00777, 1'b0, 1'b0, '0, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule